// File: doc/BRIEF.md
# Load/Store Byte Lane Unit

This block sits between a 32-bit core and a word-addressed data port. It handles the sub-word parts of loads and stores. It takes the two low bits of the effective address and the access-width code. From these it produces one enable bit per byte of the data word, and it raises a flag when the access would cross a word boundary. Crossing accesses are rejected, never split. The address sent to the bus always has its low bits cleared.

On the load side, the word returned by memory is shifted so that the selected byte or halfword lands at bit 0. It is then sign- or zero-extended. On the store side, the low byte or halfword of the register value is moved up into the enabled lanes, and every other lane is zero.

A small register keeps the lane mask of the most recent load. An atomic read-modify-write sequence uses that held mask, not the current address, when it writes the loaded value back.

Top module: `lsu_lane_unit`

## Requirements
- R1: With a byte width code (funct3 low bits = 0), an access at offset n is valid and sets only bit n of `byte_sel`.
- R2: With a halfword width code (funct3 low bits = 1), offset 0 gives `byte_sel` = 0011 and offset 2 gives 1100. Offsets 1 and 3 set `misalign`.
- R3: With a word width code (funct3 low bits = 2), offset 0 gives `byte_sel` = 1111 and every other offset sets `misalign`. The width code 3 always sets `misalign`.
- R4: Whenever `misalign` is 1, `byte_sel` is 0000, `load_data` is zero and `store_data` is zero.
- R5: `bus_addr` equals `addr` with its two low bits forced to 0.
- R6: A load moves the selected lane(s) of `rdata` to bit 0. Signed loads (funct3 0 = byte, 1 = halfword) fill the upper bits with the MSB of the selected data.
- R7: Unsigned loads (funct3 4 = byte, 5 = halfword; bit 2 of funct3 selects zero fill) clear the upper bits. A word load returns `rdata` unchanged.
- R8: A store places the low byte or halfword of `wdata` into the lanes enabled by `byte_sel`, with no extension. All other lanes are 0.
- R9: `held_sel` resets to 0000. It takes the current `byte_sel` on a clock edge where `ld_capture` is 1, and holds its value otherwise.
- R10: While `amo_wb` is 1, the load path extracts and extends using `held_sel` instead of the current mask. Signedness still comes from the current funct3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 32 | Effective byte address |
| funct3 | input | 3 | Access width and signedness code |
| ld_capture | input | 1 | Store the current lane mask into the held register |
| amo_wb | input | 1 | Use the held mask for load extraction |
| rdata | input | 32 | Word read from memory |
| wdata | input | 32 | Register value to be stored |
| bus_addr | output | 32 | Word-aligned address for the data port |
| byte_sel | output | 4 | Per-byte lane enable |
| misalign | output | 1 | Access crosses a word boundary or has a bad width code |
| load_data | output | 32 | Aligned and extended load result |
| store_data | output | 32 | Lane-placed store word |
| held_sel | output | 4 | Lane mask of the last captured load |

## Verification
A table drives one fixed read word and one fixed store value through every width code at each offset. This pins each lane position to its own byte value. Because the read word carries bytes with both set and clear MSBs, the table tells sign fill apart from zero fill and exposes a wrong lane or a swapped halfword. The misaligned rows separate rejection from silent truncation. Directed steps then use a positive halfword to show that the fill follows the data rather than being fixed ones. They also capture masks and switch to the held-mask path, where the held and current masks pick different lanes, so the two sources cannot be confused.

// File: rtl/lsu_lane_pkg.sv
`timescale 1ns/1ps
package lsu_lane_pkg;
  localparam int MAX_LANES = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  // number of bytes touched by a width code
  function automatic int lane_bytes(input logic [1:0] sz);
    return 1 << sz;
  endfunction

  // index of the lowest enabled lane, 0 when none
  function automatic int lowest_lane(input logic [MAX_LANES-1:0] m);
    int idx;
    idx = 0;
    for (int i = MAX_LANES - 1; i >= 0; i--) begin
      if (m[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/lsu_lane_mask.sv
`timescale 1ns/1ps
module lsu_lane_mask #(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size_code,
  output logic [LANES-1:0] sel,
  output logic             misalign
);
  import lsu_lane_pkg::*;

  acc_size_e size;
  int        nbytes;
  int        off_i;
  logic      fits;

  always_comb begin
    size   = acc_size_e'(size_code);
    nbytes = lane_bytes(size_code);
    off_i  = int'(offset);
    fits   = (size != SZ_BAD) && (nbytes <= LANES) && ((off_i % nbytes) == 0);
    for (int i = 0; i < LANES; i++) begin
      sel[i] = fits && (i >= off_i) && (i < off_i + nbytes);
    end
    misalign = !fits;
  end
endmodule

// File: rtl/lsu_lane_load.sv
`timescale 1ns/1ps
module lsu_lane_load #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANES-1:0]  sel,
  input  logic              zext,
  output logic [DATA_W-1:0] result
);
  import lsu_lane_pkg::*;

  logic [MAX_LANES-1:0] sel_pad;
  logic [DATA_W-1:0]    shifted;
  int                   lo;
  int                   cnt;
  logic                 fill;

  always_comb begin
    sel_pad = '0;
    sel_pad[LANES-1:0] = sel;
    lo      = lowest_lane(sel_pad);
    cnt     = $countones(sel);
    shifted = rdata >> (lo * 8);
    fill    = 1'b0;
    if (!zext && cnt > 0) fill = shifted[cnt*8-1];
    for (int b = 0; b < DATA_W; b++) begin
      result[b] = (b < cnt * 8) ? shifted[b] : fill;
    end
  end
endmodule

// File: rtl/lsu_lane_store.sv
`timescale 1ns/1ps
module lsu_lane_store #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  sel,
  output logic [DATA_W-1:0] placed
);
  import lsu_lane_pkg::*;

  logic [MAX_LANES-1:0] sel_pad;
  logic [DATA_W-1:0]    shifted;
  int                   lo;

  always_comb begin
    sel_pad = '0;
    sel_pad[LANES-1:0] = sel;
    lo      = lowest_lane(sel_pad);
    shifted = wdata << (lo * 8);
    for (int i = 0; i < LANES; i++) begin
      placed[i*8 +: 8] = sel[i] ? shifted[i*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
`timescale 1ns/1ps
module lsu_lane_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [2:0]           funct3,
  input  logic                 ld_capture,
  input  logic                 amo_wb,
  input  logic [DATA_W-1:0]    rdata,
  input  logic [DATA_W-1:0]    wdata,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W/8-1:0]  byte_sel,
  output logic                 misalign,
  output logic [DATA_W-1:0]    load_data,
  output logic [DATA_W-1:0]    store_data,
  output logic [DATA_W/8-1:0]  held_sel
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  // named internal events
  logic [LANES-1:0] cur_sel;
  logic             cur_bad;
  logic [LANES-1:0] ext_sel;
  logic             capture_evt;
  logic [LANES-1:0] held_q;

  lsu_lane_mask #(.LANES(LANES), .OFF_W(OFF_W)) u_mask (
    .offset    (addr[OFF_W-1:0]),
    .size_code (funct3[1:0]),
    .sel       (cur_sel),
    .misalign  (cur_bad)
  );

  assign capture_evt = ld_capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held_q <= '0;
    else if (capture_evt) held_q <= cur_sel;
  end

  assign ext_sel = amo_wb ? held_q : cur_sel;

  lsu_lane_load #(.DATA_W(DATA_W), .LANES(LANES)) u_load (
    .rdata  (rdata),
    .sel    (ext_sel),
    .zext   (funct3[2]),
    .result (load_data)
  );

  lsu_lane_store #(.DATA_W(DATA_W), .LANES(LANES)) u_store (
    .wdata  (wdata),
    .sel    (cur_sel),
    .placed (store_data)
  );

  assign bus_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign byte_sel = cur_sel;
  assign misalign = cur_bad;
  assign held_sel = held_q;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
`timescale 1ns/1ps
module lsu_lane_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] byte_sel,
  input logic                misalign,
  input logic [DATA_W/8-1:0] held_sel,
  input logic                ld_capture,
  input logic                amo_wb,
  input logic [2:0]          funct3,
  input logic [DATA_W-1:0]   load_data,
  input logic [DATA_W-1:0]   store_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [DATA_W-1:0] lane_bits;
  always_comb begin
    for (int i = 0; i < LANES; i++) lane_bits[i*8 +: 8] = {8{byte_sel[i]}};
  end

  // R4
  misalign_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (byte_sel == '0 && store_data == '0));

  // R5
  bus_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[OFF_W-1:0] == '0);

  // R1
  sel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !misalign |-> ($countones(byte_sel) == 1 || $countones(byte_sel) == 2 ||
                   $countones(byte_sel) == 4));

  // R9
  held_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_capture |=> held_sel == $past(byte_sel));

  // R9
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_capture |=> $stable(held_sel));

  // R8
  store_outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_data & ~lane_bits) == '0);

  // R7
  zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!amo_wb && funct3 == 3'd4) |-> load_data[DATA_W-1:8] == '0);
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .byte_sel   (byte_sel),
  .misalign   (misalign),
  .held_sel   (held_sel),
  .ld_capture (ld_capture),
  .amo_wb     (amo_wb),
  .funct3     (funct3),
  .load_data  (load_data),
  .store_data (store_data)
);

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  funct3 = '0;
  logic        ld_capture = 1'b0;
  logic        amo_wb = 1'b0;
  logic [31:0] rdata = '0;
  logic [31:0] wdata = '0;
  logic [31:0] bus_addr;
  logic [3:0]  byte_sel;
  logic        misalign;
  logic [31:0] load_data;
  logic [31:0] store_data;
  logic [3:0]  held_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsu_lane_unit u_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .funct3(funct3),
    .ld_capture(ld_capture), .amo_wb(amo_wb), .rdata(rdata), .wdata(wdata),
    .bus_addr(bus_addr), .byte_sel(byte_sel), .misalign(misalign),
    .load_data(load_data), .store_data(store_data), .held_sel(held_sel)
  );

  localparam logic [31:0] LD = 32'hF162_9374;
  localparam logic [31:0] ST = 32'hCAFE_B5A7;

  // {funct3, offset, sel, bad, load result, store word}
  localparam int NV = 18;
  localparam logic [73:0] VEC [NV] = '{
    {3'd0, 2'd0, 4'b0001, 1'b0, 32'h0000_0074, 32'h0000_00A7},
    {3'd0, 2'd1, 4'b0010, 1'b0, 32'hFFFF_FF93, 32'h0000_A700},
    {3'd0, 2'd2, 4'b0100, 1'b0, 32'h0000_0062, 32'h00A7_0000},
    {3'd0, 2'd3, 4'b1000, 1'b0, 32'hFFFF_FFF1, 32'hA700_0000},
    {3'd4, 2'd1, 4'b0010, 1'b0, 32'h0000_0093, 32'h0000_A700},
    {3'd4, 2'd3, 4'b1000, 1'b0, 32'h0000_00F1, 32'hA700_0000},
    {3'd1, 2'd0, 4'b0011, 1'b0, 32'hFFFF_9374, 32'h0000_B5A7},
    {3'd1, 2'd2, 4'b1100, 1'b0, 32'hFFFF_F162, 32'hB5A7_0000},
    {3'd5, 2'd0, 4'b0011, 1'b0, 32'h0000_9374, 32'h0000_B5A7},
    {3'd5, 2'd2, 4'b1100, 1'b0, 32'h0000_F162, 32'hB5A7_0000},
    {3'd1, 2'd1, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {3'd5, 2'd3, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {3'd2, 2'd0, 4'b1111, 1'b0, 32'hF162_9374, 32'hCAFE_B5A7},
    {3'd2, 2'd1, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {3'd2, 2'd2, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {3'd2, 2'd3, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {3'd3, 2'd0, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {3'd7, 2'd0, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset held_sel", {28'h0, held_sel}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      funct3 = VEC[k][73:71];
      addr   = {30'h048D_159E, VEC[k][70:69]};
      rdata  = LD;
      wdata  = ST;
      #1;
      if (VEC[k][64])
        chk("R4 misalign", {31'h0, misalign}, 32'h1);
      else if (funct3[1:0] == 2'd0)
        chk("R1 byte mask", {28'h0, byte_sel}, {28'h0, VEC[k][68:65]});
      else if (funct3[1:0] == 2'd1)
        chk("R2 half mask", {28'h0, byte_sel}, {28'h0, VEC[k][68:65]});
      else
        chk("R3 word mask", {28'h0, byte_sel}, {28'h0, VEC[k][68:65]});
      chk("R3 R2 R1 mask field", {27'h0, byte_sel, misalign}, {27'h0, VEC[k][68:64]});
      if (funct3[2]) chk("R7 unsigned load", load_data, VEC[k][63:32]);
      else           chk("R6 signed load", load_data, VEC[k][63:32]);
      chk("R8 store place", store_data, VEC[k][31:0]);
      chk("R5 bus addr", bus_addr, {addr[31:2], 2'b00});
    end

    // R6: positive halfword fills with zero
    @(negedge clk);
    funct3 = 3'd1; addr = 32'h0000_0002; rdata = 32'h7F00_0100;
    #1;
    chk("R6 positive half", load_data, 32'h0000_7F00);

    // R5: arbitrary address
    @(negedge clk);
    addr = 32'hDEAD_BEEF; funct3 = 3'd0;
    #1;
    chk("R5 bus addr low bits", bus_addr, 32'hDEAD_BEEC);

    // R9: capture byte lane 2
    @(negedge clk);
    funct3 = 3'd0; addr = 32'h0000_1002; ld_capture = 1'b1; rdata = LD;
    @(negedge clk);
    ld_capture = 1'b0;
    #1;
    chk("R9 capture", {28'h0, held_sel}, 32'h4);
    funct3 = 3'd2; addr = 32'h0000_2000;
    @(negedge clk);
    #1;
    chk("R9 hold", {28'h0, held_sel}, 32'h4);

    // R10: held lane 2 used instead of current lane 0
    funct3 = 3'd0; addr = 32'h0000_2000; amo_wb = 1'b1;
    #1;
    chk("R10 held byte", load_data, 32'h0000_0062);
    amo_wb = 1'b0;
    #1;
    chk("R10 current byte", load_data, 32'h0000_0074);

    // R10: held upper halfword
    @(negedge clk);
    funct3 = 3'd1; addr = 32'h0000_3002; ld_capture = 1'b1;
    @(negedge clk);
    ld_capture = 1'b0; addr = 32'h0000_3000; amo_wb = 1'b1;
    #1;
    chk("R10 held half", load_data, 32'hFFFF_F162);

    // R9 R4: capture of misaligned access holds empty mask
    @(negedge clk);
    amo_wb = 1'b0; funct3 = 3'd2; addr = 32'h0000_4001; ld_capture = 1'b1;
    @(negedge clk);
    ld_capture = 1'b0;
    #1;
    chk("R9 capture misaligned", {28'h0, held_sel}, 32'h0);
    amo_wb = 1'b1;
    #1;
    chk("R10 empty held mask", load_data, 32'h0);
    amo_wb = 1'b0;

    done = 1'b1;
    summary();
  end
endmodule